// File: doc/BRIEF.md
# Composite Selectable Clock Divider Cell

This cell produces one derived clock from a set of source clocks. A source switch picks either a primary clock or one of several secondary clocks; the secondary clock is chosen by a 3-bit select. The chosen clock then goes through one of three paths: straight through (ratio 1), a programmable divider whose ratio comes from a small nonlinear table, or a fixed divide-by-3. The fixed path always wins when it is switched on. An enable then gates the result, and the output is held low while the enable is off.

Software sets the cell up through a small write-only register port that runs on its own configuration clock. Divider and enable settings cross into the selected clock's domain through synchronizers. They are applied only on a period boundary, or while the output is low, so a change never cuts a pulse short. The source selector and the gate can each be left out at build time.

Top module: `clkdiv_cell`

## Requirements
- R1: After reset every register field is 0, the enable is off and `clk_out` stays low with no edges.
- R2: With the source switch (address 0, bit 0) at 0, the primary clock drives the divider, whatever the secondary select holds.
- R3: With the source switch at 1, the secondary select (address 0, bits 3:1) picks `sec_clk[k]` for k below NUM_SEC. Select values at or above NUM_SEC fall back to the primary clock.
- R4: With the fixed switch (address 1, bit 4) at 0 and the divider switch (address 1, bit 0) at 1, ratio codes 0 to 5 (address 1, bits 3:1) divide by 1, 2, 4, 6, 8 and 12. Even ratios give a 50% duty cycle.
- R5: With both the fixed switch and the divider switch at 0, the output has the period and duty of the selected clock (ratio 1).
- R6: With the fixed switch at 1, the output is the selected clock divided by 3, high for one source period and low for two, whatever the divider switch and code hold.
- R7: The enable (address 2, bit 0) gates the output. While it is 0, `clk_out` is low and has no edges.
- R8: A new ratio takes effect only at the end of the current output period. Across the change every high and low phase has the full length of either the old ratio or the new one.
- R9: Changes to the enable are applied only while the output is low, so every high pulse has its full length however the enable toggles.
- R10: Ratio codes 6 and 7 divide by 1.
- R11: A build with the source selector removed (HAS_MUX=0) always runs from the primary clock. A build with the gate removed (HAS_GATE=0) runs whatever the enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock for the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 source, 1 divider, 2 enable |
| wr_data | input | 8 | Register write data |
| pri_clk | input | 1 | Primary source clock |
| sec_clk | input | NUM_SEC | Secondary source clocks |
| clk_out | output | 1 | Divided and gated output clock |

## Verification
The bench measures the period and high time of every output pulse in real time. It compares them against values computed from each source period and the ratio table, over all eight codes, both fixed-path settings, every secondary input and an out-of-range select. A wrong table entry or a fixed path that does not dominate shows up as a wrong period. A selector that ignores the source switch or decodes the select off by one shows up as the wrong source period. While the ratio is changed mid-run and the enable is toggled at irregular times, a pulse-width watcher flags any phase that is not a full old-ratio or new-ratio length; it would catch a design that reloads mid-period or gates on a high phase. A second build without the selector and gate has to keep running from the primary clock with the enable off.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = 3;
  localparam int CODE_W  = 3;
  localparam int RATIO_W = 4;
  localparam int SEL_N   = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] ADDR_SRC  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_GATE = 2'd2;

  localparam int F_ALT     = 0;
  localparam int F_SEL_LO  = 1;
  localparam int F_DSW     = 0;
  localparam int F_CODE_LO = 1;
  localparam int F_DIV3    = 4;
  localparam int F_EN      = 0;

  typedef struct packed {
    logic             alt;
    logic [SEL_W-1:0] sel;
  } src_cfg_t;

  typedef struct packed {
    logic              div3;
    logic              dsw;
    logic [CODE_W-1:0] code;
    logic              en;
  } div_cfg_t;

  function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
    logic [RATIO_W-1:0] r;
    case (c)
      3'd1:    r = 4'd2;
      3'd2:    r = 4'd4;
      3'd3:    r = 4'd6;
      3'd4:    r = 4'd8;
      3'd5:    r = 4'd12;
      default: r = 4'd1;
    endcase
    return r;
  endfunction

  function automatic logic [RATIO_W-1:0] ratio_of(input div_cfg_t c);
    logic [RATIO_W-1:0] r;
    if (c.div3)      r = 4'd3;
    else if (!c.dsw) r = 4'd1;
    else             r = code_ratio(c.code);
    return r;
  endfunction

  function automatic logic [RATIO_W-1:0] high_of(input div_cfg_t c);
    logic [RATIO_W-1:0] h;
    if (c.div3) h = 4'd1;
    else        h = ratio_of(c) >> 1;
    return h;
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nxt;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_sync_bus.sv
`timescale 1ns/1ps
module clkdiv_sync_bus #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_in;
    if (s == 0) begin : g_first
      assign stg_in = d;
    end else begin : g_next
      assign stg_in = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_in;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
  import clkdiv_pkg::*;
(
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output src_cfg_t          src_cfg,
  output div_cfg_t          div_cfg
);
  src_cfg_t src_q, src_nxt;
  div_cfg_t div_q, div_nxt;
  logic     src_we, div_we, gate_we;
  logic     unused_wr;

  assign unused_wr = ^wr_data[DATA_W-1:F_DIV3+1];

  always_comb begin
    src_we  = wr_en && (wr_addr == ADDR_SRC);
    div_we  = wr_en && (wr_addr == ADDR_DIV);
    gate_we = wr_en && (wr_addr == ADDR_GATE);

    src_nxt     = src_q;
    src_nxt.alt = wr_data[F_ALT];
    src_nxt.sel = wr_data[F_SEL_LO +: SEL_W];

    div_nxt = div_q;
    if (div_we) begin
      div_nxt.dsw  = wr_data[F_DSW];
      div_nxt.code = wr_data[F_CODE_LO +: CODE_W];
      div_nxt.div3 = wr_data[F_DIV3];
    end
    if (gate_we) begin
      div_nxt.en = wr_data[F_EN];
    end
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_we) src_q <= src_nxt;
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n)                  div_q <= '0;
    else if (div_we || gate_we)  div_q <= div_nxt;
  end

  assign src_cfg = src_q;
  assign div_cfg = div_q;

  // R7: an enable write lands in the register on the next cycle
  a_r7_enable_write: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_GATE) |=> (div_cfg.en == $past(wr_data[F_EN])));

  // R3: the source fields hold when no source write occurs
  a_r3_src_hold: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_SRC) |=> $stable(src_cfg));
endmodule

// File: rtl/clkdiv_src_mux.sv
`timescale 1ns/1ps
module clkdiv_src_mux
  import clkdiv_pkg::*;
#(
  parameter int NUM_SEC = 4,
  parameter bit HAS_MUX = 1'b1
) (
  input  logic               pri_clk,
  input  logic [NUM_SEC-1:0] sec_clk,
  input  src_cfg_t           src_cfg,
  output logic               clk_sel
);
  if (HAS_MUX) begin : g_mux
    logic [SEL_N-1:0] padded;
    for (genvar i = 0; i < SEL_N; i++) begin : g_in
      if (i < NUM_SEC) begin : g_sec
        assign padded[i] = sec_clk[i];
      end else begin : g_fallback
        assign padded[i] = pri_clk;
      end
    end
    assign clk_sel = src_cfg.alt ? padded[src_cfg.sel] : pri_clk;
  end else begin : g_fixed
    logic unused_src;
    assign unused_src = ^{src_cfg, sec_clk};
    assign clk_sel = pri_clk;
  end
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter bit HAS_GATE    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  div_cfg_t cfg_in,
  output logic     clk_out
);
  localparam int CFG_W = $bits(div_cfg_t);

  logic [CFG_W-1:0]   cfg_sync;
  div_cfg_t           cfg_d_q, pend_q;
  logic               pend_ld;
  logic [RATIO_W-1:0] cnt_q, cnt_nxt;
  logic [RATIO_W-1:0] ratio_q, ratio_nxt;
  logic [RATIO_W-1:0] hi_q, hi_nxt;
  logic               div_q, div_nxt;
  logic               period_end;
  logic               mode1;
  logic               gate_on;

  clkdiv_sync_bus #(.WIDTH(CFG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cfg_in),
    .q     (cfg_sync)
  );

  // accept a setting only after it has been seen on two edges in a row
  always_comb begin
    pend_ld = (cfg_d_q == div_cfg_t'(cfg_sync));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_d_q <= '0;
    else        cfg_d_q <= div_cfg_t'(cfg_sync);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ld) pend_q <= cfg_d_q;
  end

  always_comb begin
    period_end = (cnt_q == ratio_q - RATIO_W'(1));
    if (period_end) begin
      cnt_nxt   = '0;
      ratio_nxt = ratio_of(pend_q);
      hi_nxt    = high_of(pend_q);
      div_nxt   = 1'b1;
    end else begin
      cnt_nxt   = cnt_q + RATIO_W'(1);
      ratio_nxt = ratio_q;
      hi_nxt    = hi_q;
      div_nxt   = (cnt_q + RATIO_W'(1)) < hi_q;
    end
    mode1 = (ratio_q == RATIO_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(1);
      hi_q    <= '0;
      div_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      ratio_q <= ratio_nxt;
      hi_q    <= hi_nxt;
      div_q   <= div_nxt;
    end
  end

  if (HAS_GATE) begin : g_gate
    logic gate_q, gate_nxt, gate_ld;

    always_comb begin
      gate_ld  = mode1 || !div_q;
      gate_nxt = pend_q.en;
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)       gate_q <= 1'b0;
      else if (gate_ld) gate_q <= gate_nxt;
    end

    assign gate_on = gate_q;

    // R9: the gate only moves while the divided output is low
    a_r9_gate_when_low: assert property (@(negedge clk) disable iff (!rst_n)
      (gate_q != $past(gate_q)) |-> ($past(ratio_q) == RATIO_W'(1) || !$past(div_q)));
  end else begin : g_nogate
    logic unused_en;
    assign unused_en = pend_q.en;
    assign gate_on   = 1'b1;
  end

  assign clk_out = gate_on & (mode1 ? clk : div_q);

  // R4: the counter never leaves the active ratio range
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  // R4: even ratios fall exactly at half the period
  a_r4_even_duty: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_q) && ratio_q != RATIO_W'(3) && ratio_q != RATIO_W'(1)) |-> (cnt_q == hi_q));

  // R6: divide-by-3 output is high for a single source period
  a_r6_div3_high_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q == RATIO_W'(3) && $rose(div_q)) |=> !div_q);

  // R8: the ratio only reloads at the last count of a period
  a_r8_reload_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_q != $past(ratio_q)) |-> ($past(cnt_q) == $past(ratio_q) - RATIO_W'(1)));
endmodule

// File: rtl/clkdiv_cell.sv
`timescale 1ns/1ps
module clkdiv_cell
  import clkdiv_pkg::*;
#(
  parameter int NUM_SEC     = 4,
  parameter bit HAS_MUX     = 1'b1,
  parameter bit HAS_GATE    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic               cfg_clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               pri_clk,
  input  logic [NUM_SEC-1:0] sec_clk,
  output logic               clk_out
);
  logic     cfg_rst_n;
  logic     div_rst_n;
  logic     clk_sel;
  src_cfg_t src_cfg;
  div_cfg_t div_cfg;

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_cfg_rst (
    .clk        (cfg_clk),
    .rst_n      (rst_n),
    .rst_n_sync (cfg_rst_n)
  );

  clkdiv_regs u_regs (
    .cfg_clk (cfg_clk),
    .rst_n   (cfg_rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .src_cfg (src_cfg),
    .div_cfg (div_cfg)
  );

  clkdiv_src_mux #(.NUM_SEC(NUM_SEC), .HAS_MUX(HAS_MUX)) u_mux (
    .pri_clk (pri_clk),
    .sec_clk (sec_clk),
    .src_cfg (src_cfg),
    .clk_sel (clk_sel)
  );

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_div_rst (
    .clk        (clk_sel),
    .rst_n      (rst_n),
    .rst_n_sync (div_rst_n)
  );

  clkdiv_core #(.HAS_GATE(HAS_GATE), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk     (clk_sel),
    .rst_n   (div_rst_n),
    .cfg_in  (div_cfg),
    .clk_out (clk_out)
  );
endmodule

// File: tb/test_clkdiv_cell.sv
`timescale 1ns/1ps
module test_clkdiv_cell;
  localparam int NSEC = 4;

  logic cfg_clk = 1'b0;
  logic pri     = 1'b0;
  logic s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
  always #2 cfg_clk = ~cfg_clk;   // 250 MHz
  always #5 pri = ~pri;           // 10 ns
  always #3 s0 = ~s0;             // 6 ns
  always #4 s1 = ~s1;             // 8 ns
  always #6 s2 = ~s2;             // 12 ns
  always #7 s3 = ~s3;             // 14 ns

  logic [NSEC-1:0] sec;
  assign sec = {s3, s2, s1, s0};

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       clk_out, clk_out_min;

  clkdiv_cell #(.NUM_SEC(NSEC)) i_clkdiv_cell (
    .cfg_clk (cfg_clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .pri_clk (pri), .sec_clk (sec), .clk_out (clk_out)
  );

  clkdiv_cell #(.NUM_SEC(NSEC), .HAS_MUX(1'b0), .HAS_GATE(1'b0)) i_clkdiv_cell_min (
    .cfg_clk (cfg_clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .pri_clk (pri), .sec_clk (sec), .clk_out (clk_out_min)
  );

  int checks = 0;
  int errors = 0;

  typedef struct { real per; real hi; string tag; } exp_t;
  exp_t exp_q[$];
  int   popped = 0;
  bit   arm = 1'b0;

  real  t_rise = 0.0, t_fall = 0.0;
  bit   have_rise = 0, have_fall = 0, have_prev = 0;
  int   edge_cnt = 0, edge_min = 0;
  bit   watch_hi = 0, watch_lo = 0;
  real  allow_a = 0.0, allow_b = 0.0;
  int   bad_cnt = 0;
  real  bad_w = 0.0;

  function automatic bit close(real a, real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  // monitor: measures each output period and compares against the scoreboard
  always @(posedge clk_out) begin
    real now;
    exp_t e;
    now = $realtime;
    edge_cnt++;
    if (watch_lo && have_fall && !(close(now - t_fall, allow_a) || close(now - t_fall, allow_b))) begin
      bad_cnt++;
      bad_w = now - t_fall;
    end
    if (!arm) begin
      have_prev = 0;
    end else begin
      if (have_prev && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        checks += 2;
        if (!close(now - t_rise, e.per)) begin
          errors++;
          $display("FAIL %s period: actual %0.3f expected %0.3f", e.tag, now - t_rise, e.per);
        end
        if (!close(t_fall - t_rise, e.hi)) begin
          errors++;
          $display("FAIL %s high time: actual %0.3f expected %0.3f", e.tag, t_fall - t_rise, e.hi);
        end
        popped++;
      end
      have_prev = 1;
    end
    t_rise = now;
    have_rise = 1;
  end

  always @(negedge clk_out) begin
    real now;
    now = $realtime;
    if (watch_hi && have_rise && !(close(now - t_rise, allow_a) || close(now - t_rise, allow_b))) begin
      bad_cnt++;
      bad_w = now - t_rise;
    end
    t_fall = now;
    have_fall = 1;
  end

  always @(posedge clk_out_min) edge_min++;

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge cfg_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge cfg_clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes expected periods, then arms the monitor until they are consumed
  task automatic expect_run(input real per, input real hi, input int n, input string tag);
    int target;
    #700;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.per = per; e.hi = hi; e.tag = tag;
      exp_q.push_back(e);
    end
    target = popped + n;
    arm = 1'b1;
    wait (popped == target);
    arm = 1'b0;
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] div_word(input bit div3, input int code, input bit dsw);
    return 8'((int'(div3) << 4) | (code << 1) | int'(dsw));
  endfunction

  initial begin
    #120000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    real ratio_tab[8];
    real src_per[NSEC];
    int  e0;
    ratio_tab = '{1.0, 2.0, 4.0, 6.0, 8.0, 12.0, 1.0, 1.0};
    src_per   = '{6.0, 8.0, 12.0, 14.0};

    #50;
    @(negedge cfg_clk);
    rst_n = 1'b1;
    #200;
    check_int("R1 output low after reset", int'(clk_out), 0);
    check_int("R1 no edges after reset", edge_cnt, 0);

    // R5: only the enable is set, reset fields give ratio 1 on the primary clock
    wr(2'd2, 8'h01);
    expect_run(10.0, 5.0, 3, "R5 ratio 1 from reset fields");

    // R4 and R10: sweep all ratio codes on the primary clock
    for (int c = 0; c < 8; c++) begin
      real r;
      r = ratio_tab[c];
      wr(2'd1, div_word(1'b0, c, 1'b1));
      if (r == 1.0) expect_run(10.0, 5.0, 3, $sformatf("R10 code %0d", c));
      else          expect_run(10.0 * r, 5.0 * r, 3, $sformatf("R4 code %0d", c));
    end

    // R6: fixed divide-by-3 dominates the programmable path
    wr(2'd1, div_word(1'b1, 5, 1'b1));
    expect_run(30.0, 10.0, 3, "R6 div3 over code 5");
    wr(2'd1, div_word(1'b1, 0, 1'b0));
    expect_run(30.0, 10.0, 3, "R6 div3 with divider switch off");

    // R3: each secondary input at ratio 2
    wr(2'd1, div_word(1'b0, 1, 1'b1));
    for (int k = 0; k < NSEC; k++) begin
      wr(2'd0, 8'((k << 1) | 1));
      expect_run(2.0 * src_per[k], src_per[k], 3, $sformatf("R3 secondary %0d", k));
    end
    wr(2'd0, 8'((5 << 1) | 1));
    expect_run(20.0, 10.0, 3, "R3 out-of-range select uses primary");

    // R2: switch at 0 ignores the secondary select
    wr(2'd0, 8'(2 << 1));
    expect_run(20.0, 10.0, 3, "R2 primary with select 2 held");

    // R8: ratio 4 to ratio 12 mid-run, every phase is 20 or 60 ns
    wr(2'd1, div_word(1'b0, 2, 1'b1));
    #700;
    allow_a = 20.0; allow_b = 60.0; bad_cnt = 0;
    watch_hi = 1; watch_lo = 1;
    #33;
    wr(2'd1, div_word(1'b0, 5, 1'b1));
    #1200;
    watch_hi = 0; watch_lo = 0;
    checks++;
    if (bad_cnt != 0) begin
      errors++;
      $display("FAIL R8 phase width: actual %0.3f expected 20 or 60", bad_w);
    end
    expect_run(120.0, 60.0, 2, "R8 new ratio active");

    // R9: irregular enable toggling at ratio 4, every high pulse is 20 ns
    wr(2'd1, div_word(1'b0, 2, 1'b1));
    #700;
    allow_a = 20.0; allow_b = 20.0; bad_cnt = 0;
    watch_hi = 1;
    for (int i = 0; i < 6; i++) begin
      wr(2'd2, 8'h00);
      #(37 + i * 13);
      wr(2'd2, 8'h01);
      #(53 + i * 7);
    end
    #300;
    watch_hi = 0;
    checks++;
    if (bad_cnt != 0) begin
      errors++;
      $display("FAIL R9 high pulse: actual %0.3f expected 20", bad_w);
    end
    expect_run(40.0, 20.0, 2, "R9 output running after toggles");

    // R7: enable off holds the output low
    wr(2'd2, 8'h00);
    #700;
    e0 = edge_cnt;
    #500;
    check_int("R7 no edges while disabled", edge_cnt - e0, 0);
    check_int("R7 output low while disabled", int'(clk_out), 0);

    // R11: build without selector and gate keeps running from the primary clock
    wr(2'd0, 8'((1 << 1) | 1));
    #700;
    e0 = edge_min;
    #400;
    checks++;
    if (edge_min - e0 < 9 || edge_min - e0 > 11) begin
      errors++;
      $display("FAIL R11 reduced build edges: actual %0d expected 10", edge_min - e0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule